// File: doc/BRIEF.md
# Link Training State Transition Monitor

The block watches the 5-bit training-state code that a serial link controller reports. It judges every change of that code against a fixed set of 57 permitted moves between 30 named states. Each permitted move owns one sticky bit in a hit vector, so a run of traffic leaves a record of which moves were exercised. A flag goes high once every bit is set. Any move outside the set raises a sticky error and records the offending pair of codes. The same happens when either of the two unassigned codes shows up.

The monitor can sit on a live controller as a synthesizable safety net, or in a test environment as a coverage collector. It only compares codes. It does not generate link states or look at line traffic. A sample counts only while the valid strobe is high. A one-cycle clear pulse re-arms the error capture.

Top module: `link_arc_monitor`

## Requirements
- R1: While the synchronous reset is high, and in the first cycle after it, the hit vector, error flag, captured pair and covered flag are all zero.
- R2: The first valid sample after reset only records the current code and is not checked, unless the code is unassigned.
- R3: A valid sample equal to the previously recorded code neither sets a hit bit nor raises the error.
- R4: The codes are: 0x00 quiet-detect, 0x01 active-detect, 0x02 poll-active, 0x03 poll-compliance, 0x04 poll-config, 0x05 pre-detect, 0x06 detect-wait, 0x07 width-start, 0x08 width-accept, 0x09 lane-wait, 0x0A lane-accept, 0x0B config-done, 0x0C config-idle, 0x0D recovery-lock, 0x0E recovery-config, 0x0F recovery-idle, 0x10 L0, 0x11 L0s, 0x12 send-idle, 0x13 L1-idle, 0x14 L2-idle, 0x16 disable-entry, 0x17 disable-idle, 0x18 disabled, 0x19 loop-entry, 0x1A loop-active, 0x1B loop-exit, 0x1C loop-exit-timeout, 0x1D hot-reset-entry, 0x1F hot-reset. The permitted moves, written from→to, are 00→01; 01→00/02/06; 02→03/04/05; 03→02; 04→05/07; 05→00; 06→01; 07→05/08/16/19; 08→05/09; 09→05; 0A→05/08/09/0B; 0B→05/0C; 0C→05/10; 0D→05/07/0E; 0E→05/07/0F; 0F→05/07/16/19/1D; 10→0D/11/12; 11→0D/10; 12→13/14; 13→0D; 16→17; 17→00/18; 18→00; 19→05/1A; 1A→1B; 1B→1C; 1C→00; 1D→1F; 1F→05. Hit bit k belongs to the k-th move when the list is sorted by from-code and then by to-code, both ascending, starting at k=0. Bit k is set in the cycle after the sample that completes move k.
- R5: A change between two assigned codes that is not a permitted move raises the error flag in the next cycle. The previous code is captured as the from-code and the new code as the to-code, and the hit vector does not change.
- R6: A valid sample of code 0x15 or 0x1E raises the error. The to-code is that code, and the from-code is the previously recorded code, or the same code when it is the first sample after reset.
- R7: While the error flag is set and no clear is pulsed, later violations leave the flag set and the captured pair unchanged.
- R8: A clear pulse drops the error flag in the next cycle. If a violation arrives in the same cycle as the clear, the flag stays set and the new pair is captured.
- R9: Samples with the valid strobe low are ignored. They do not update the recorded code, set hit bits or raise the error.
- R10: Hit bits are cleared only by reset. The covered flag is high exactly when all 57 bits are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleValid | input | 1 | Qualifies sampleCode in this cycle |
| sampleCode | input | 5 | Reported training-state code |
| errClear | input | 1 | One-cycle pulse that drops the error flag |
| hitVec | output | 57 | Sticky bit per permitted move, ordered as in R4 |
| errFlag | output | 1 | Sticky violation flag |
| errFrom | output | 5 | From-code of the captured violation |
| errTo | output | 5 | To-code of the captured violation |
| allCovered | output | 1 | High when every hit bit is set |

## Verification
The bench holds samples and clears in many cycles, so each case rests on one sample rather than on back-to-back traffic.

It targets these corner cases:
- **First sample after reset.** A design that checked it would flag a bogus move from code 0.
- **Repeated codes.** A design that counted them as moves would flag an error or set a hit bit.
- **Invalid-strobe samples.** A design that took them would move its recorded code, and the next real move would be judged from the wrong state.
- **Clear and violation in the same cycle.** A design that let the clear win would lose a violation.
- **Captured pair under a second violation.** A design that overwrote it would report the latest violation instead of the first.
- **Unassigned codes.** The bench checks them both as a first sample and after an assigned code, because their from-code comes from different places.
- **Full walk over all moves.** The bench walks every permitted move and then resets. A misordered or missing table entry shows up as a wrong bit or a low covered flag.

// File: rtl/link_arc_pkg.sv
package link_arc_pkg;

  localparam int CODE_W   = 5;
  localparam int NUM_ARCS = 57;
  localparam int PAIR_W   = 2 * CODE_W;

  typedef logic [CODE_W-1:0] code_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadPrev;    // record the sampled code
    logic setHit;      // OR matching arc into the hit vector
    logic captureErr;  // set error flag and capture the pair
    logic clearErr;    // drop the error flag
    logic fromIsCur;   // captured from-code is the sample itself
  } arc_strobes_t;

  localparam code_t CODE_HOLE_A = 5'h15;
  localparam code_t CODE_HOLE_B = 5'h1E;

  // Permitted move k as {from, to}; sorted by from then to
  function automatic logic [PAIR_W-1:0] arcPair(input int idx);
    logic [PAIR_W-1:0] p;
    case (idx)
      0:  p = {5'h00, 5'h01};
      1:  p = {5'h01, 5'h00};
      2:  p = {5'h01, 5'h02};
      3:  p = {5'h01, 5'h06};
      4:  p = {5'h02, 5'h03};
      5:  p = {5'h02, 5'h04};
      6:  p = {5'h02, 5'h05};
      7:  p = {5'h03, 5'h02};
      8:  p = {5'h04, 5'h05};
      9:  p = {5'h04, 5'h07};
      10: p = {5'h05, 5'h00};
      11: p = {5'h06, 5'h01};
      12: p = {5'h07, 5'h05};
      13: p = {5'h07, 5'h08};
      14: p = {5'h07, 5'h16};
      15: p = {5'h07, 5'h19};
      16: p = {5'h08, 5'h05};
      17: p = {5'h08, 5'h09};
      18: p = {5'h09, 5'h05};
      19: p = {5'h0A, 5'h05};
      20: p = {5'h0A, 5'h08};
      21: p = {5'h0A, 5'h09};
      22: p = {5'h0A, 5'h0B};
      23: p = {5'h0B, 5'h05};
      24: p = {5'h0B, 5'h0C};
      25: p = {5'h0C, 5'h05};
      26: p = {5'h0C, 5'h10};
      27: p = {5'h0D, 5'h05};
      28: p = {5'h0D, 5'h07};
      29: p = {5'h0D, 5'h0E};
      30: p = {5'h0E, 5'h05};
      31: p = {5'h0E, 5'h07};
      32: p = {5'h0E, 5'h0F};
      33: p = {5'h0F, 5'h05};
      34: p = {5'h0F, 5'h07};
      35: p = {5'h0F, 5'h16};
      36: p = {5'h0F, 5'h19};
      37: p = {5'h0F, 5'h1D};
      38: p = {5'h10, 5'h0D};
      39: p = {5'h10, 5'h11};
      40: p = {5'h10, 5'h12};
      41: p = {5'h11, 5'h0D};
      42: p = {5'h11, 5'h10};
      43: p = {5'h12, 5'h13};
      44: p = {5'h12, 5'h14};
      45: p = {5'h13, 5'h0D};
      46: p = {5'h16, 5'h17};
      47: p = {5'h17, 5'h00};
      48: p = {5'h17, 5'h18};
      49: p = {5'h18, 5'h00};
      50: p = {5'h19, 5'h05};
      51: p = {5'h19, 5'h1A};
      52: p = {5'h1A, 5'h1B};
      53: p = {5'h1B, 5'h1C};
      54: p = {5'h1C, 5'h00};
      55: p = {5'h1D, 5'h1F};
      56: p = {5'h1F, 5'h05};
      // never matches a distinct-code pair
      default: p = {5'h15, 5'h15};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/link_arc_matcher.sv
module link_arc_matcher
  import link_arc_pkg::*;
#(
  parameter int CodeW   = CODE_W,
  parameter int NumArcs = NUM_ARCS
) (
  input  logic [CodeW-1:0]   fromCode,
  input  logic [CodeW-1:0]   toCode,
  output logic [NumArcs-1:0] arcMatch
);

  localparam int PairW = 2 * CodeW;

  logic [PairW-1:0] pairNow;
  assign pairNow = {fromCode, toCode};

  for (genvar g = 0; g < NumArcs; g++) begin : g_arc
    localparam logic [PairW-1:0] ArcP = PairW'(arcPair(g));
    assign arcMatch[g] = (pairNow == ArcP);
  end

endmodule

// File: rtl/link_arc_control.sv
module link_arc_control
  import link_arc_pkg::*;
#(
  parameter int CodeW   = CODE_W,
  parameter int NumArcs = NUM_ARCS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sampleValid,
  input  logic [CodeW-1:0]   sampleCode,
  input  logic               errClear,
  input  logic [CodeW-1:0]   prevCode,
  input  logic [NumArcs-1:0] arcMatch,
  input  logic               errFlag,
  output arc_strobes_t       strobes
);

  logic prevValid;
  logic isHole;
  logic isChange;
  logic arcLegal;
  logic violation;

  always_ff @(posedge clk) begin
    if (rst) prevValid <= 1'b0;
    else if (sampleValid) prevValid <= 1'b1;
  end

  assign isHole    = (sampleCode == CodeW'(CODE_HOLE_A)) ||
                     (sampleCode == CodeW'(CODE_HOLE_B));
  assign isChange  = prevValid && (sampleCode != prevCode);
  assign arcLegal  = |arcMatch;
  assign violation = sampleValid && (isHole || (isChange && !arcLegal));

  always_comb begin
    strobes            = '0;
    strobes.loadPrev   = sampleValid;
    strobes.setHit     = sampleValid && isChange;
    strobes.captureErr = violation && (!errFlag || errClear);
    strobes.clearErr   = errClear;
    strobes.fromIsCur  = !prevValid;
  end

endmodule

// File: rtl/link_arc_datapath.sv
module link_arc_datapath
  import link_arc_pkg::*;
#(
  parameter int CodeW   = CODE_W,
  parameter int NumArcs = NUM_ARCS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CodeW-1:0]   sampleCode,
  input  arc_strobes_t       strobes,
  output logic [CodeW-1:0]   prevCode,
  output logic [NumArcs-1:0] arcMatch,
  output logic [NumArcs-1:0] hitVec,
  output logic               errFlag,
  output logic [CodeW-1:0]   errFrom,
  output logic [CodeW-1:0]   errTo
);

  link_arc_matcher #(.CodeW(CodeW), .NumArcs(NumArcs)) matcher_i (
    .fromCode (prevCode),
    .toCode   (sampleCode),
    .arcMatch (arcMatch)
  );

  always_ff @(posedge clk) begin
    if (rst) prevCode <= '0;
    else if (strobes.loadPrev) prevCode <= sampleCode;
  end

  always_ff @(posedge clk) begin
    if (rst) hitVec <= '0;
    else if (strobes.setHit) hitVec <= hitVec | arcMatch;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      errFlag <= 1'b0;
      errFrom <= '0;
      errTo   <= '0;
    end else if (strobes.captureErr) begin
      errFlag <= 1'b1;
      errFrom <= strobes.fromIsCur ? sampleCode : prevCode;
      errTo   <= sampleCode;
    end else if (strobes.clearErr) begin
      errFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/link_arc_monitor.sv
module link_arc_monitor
  import link_arc_pkg::*;
#(
  parameter int CodeW   = CODE_W,
  parameter int NumArcs = NUM_ARCS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sampleValid,
  input  logic [CodeW-1:0]   sampleCode,
  input  logic               errClear,
  output logic [NumArcs-1:0] hitVec,
  output logic               errFlag,
  output logic [CodeW-1:0]   errFrom,
  output logic [CodeW-1:0]   errTo,
  output logic               allCovered
);

  arc_strobes_t       strobes;
  logic [CodeW-1:0]   prevCode;
  logic [NumArcs-1:0] arcMatch;

  link_arc_control #(.CodeW(CodeW), .NumArcs(NumArcs)) ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .sampleValid (sampleValid),
    .sampleCode  (sampleCode),
    .errClear    (errClear),
    .prevCode    (prevCode),
    .arcMatch    (arcMatch),
    .errFlag     (errFlag),
    .strobes     (strobes)
  );

  link_arc_datapath #(.CodeW(CodeW), .NumArcs(NumArcs)) dp_i (
    .clk        (clk),
    .rst        (rst),
    .sampleCode (sampleCode),
    .strobes    (strobes),
    .prevCode   (prevCode),
    .arcMatch   (arcMatch),
    .hitVec     (hitVec),
    .errFlag    (errFlag),
    .errFrom    (errFrom),
    .errTo      (errTo)
  );

  assign allCovered = &hitVec;

endmodule

// File: rtl/link_arc_monitor_chk.sv
module link_arc_monitor_chk #(
  parameter int CodeW   = 5,
  parameter int NumArcs = 57
) (
  input logic               clk,
  input logic               rst,
  input logic               sampleValid,
  input logic [CodeW-1:0]   sampleCode,
  input logic               errClear,
  input logic [NumArcs-1:0] hitVec,
  input logic               errFlag,
  input logic [CodeW-1:0]   errFrom,
  input logic [CodeW-1:0]   errTo,
  input logic               allCovered
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (hitVec == '0) && !errFlag && !allCovered);

  assert_one_new_hit_R4: assert property (@(posedge clk) disable iff (rst)
    $countones(hitVec & ~$past(hitVec)) <= 1);

  assert_unassigned_err_R6: assert property (@(posedge clk) disable iff (rst)
    sampleValid && ((sampleCode == 5'h15) || (sampleCode == 5'h1E))
      |=> errFlag);

  assert_hold_pair_R7: assert property (@(posedge clk) disable iff (rst)
    errFlag && !errClear |=> errFlag && $stable(errFrom) && $stable(errTo));

  assert_clear_drops_R8: assert property (@(posedge clk) disable iff (rst)
    errClear && !sampleValid |=> !errFlag);

  assert_idle_no_hit_R9: assert property (@(posedge clk) disable iff (rst)
    !sampleValid |=> $stable(hitVec));

  assert_idle_no_err_R9: assert property (@(posedge clk) disable iff (rst)
    !sampleValid && !errClear |=> $stable(errFlag) && $stable(errFrom) && $stable(errTo));

  assert_hits_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(hitVec) & ~hitVec) == '0);

  assert_covered_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    allCovered |=> allCovered);

endmodule

bind link_arc_monitor link_arc_monitor_chk #(.CodeW(CodeW), .NumArcs(NumArcs)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .sampleValid (sampleValid),
  .sampleCode  (sampleCode),
  .errClear    (errClear),
  .hitVec      (hitVec),
  .errFlag     (errFlag),
  .errFrom     (errFrom),
  .errTo       (errTo),
  .allCovered  (allCovered)
);

// File: tb/link_arc_monitor_tb_top.sv
`timescale 1ns/1ps
module link_arc_monitor_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sampleValid = 1'b0;
  logic [4:0]  sampleCode = '0;
  logic        errClear = 1'b0;
  logic [56:0] hitVec;
  logic        errFlag;
  logic [4:0]  errFrom;
  logic [4:0]  errTo;
  logic        allCovered;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  link_arc_monitor dut_i (
    .clk(clk), .rst(rst), .sampleValid(sampleValid), .sampleCode(sampleCode),
    .errClear(errClear), .hitVec(hitVec), .errFlag(errFlag),
    .errFrom(errFrom), .errTo(errTo), .allCovered(allCovered)
  );

  // Index of a permitted move in the R4 ordering, -1 if not permitted
  function automatic int arcIdx(input logic [4:0] f, input logic [4:0] t);
    case ({f, t})
      {5'h00,5'h01}: return 0;  {5'h01,5'h00}: return 1;
      {5'h01,5'h02}: return 2;  {5'h01,5'h06}: return 3;
      {5'h02,5'h03}: return 4;  {5'h02,5'h04}: return 5;
      {5'h02,5'h05}: return 6;  {5'h03,5'h02}: return 7;
      {5'h04,5'h05}: return 8;  {5'h04,5'h07}: return 9;
      {5'h05,5'h00}: return 10; {5'h06,5'h01}: return 11;
      {5'h07,5'h05}: return 12; {5'h07,5'h08}: return 13;
      {5'h07,5'h16}: return 14; {5'h07,5'h19}: return 15;
      {5'h08,5'h05}: return 16; {5'h08,5'h09}: return 17;
      {5'h09,5'h05}: return 18; {5'h0A,5'h05}: return 19;
      {5'h0A,5'h08}: return 20; {5'h0A,5'h09}: return 21;
      {5'h0A,5'h0B}: return 22; {5'h0B,5'h05}: return 23;
      {5'h0B,5'h0C}: return 24; {5'h0C,5'h05}: return 25;
      {5'h0C,5'h10}: return 26; {5'h0D,5'h05}: return 27;
      {5'h0D,5'h07}: return 28; {5'h0D,5'h0E}: return 29;
      {5'h0E,5'h05}: return 30; {5'h0E,5'h07}: return 31;
      {5'h0E,5'h0F}: return 32; {5'h0F,5'h05}: return 33;
      {5'h0F,5'h07}: return 34; {5'h0F,5'h16}: return 35;
      {5'h0F,5'h19}: return 36; {5'h0F,5'h1D}: return 37;
      {5'h10,5'h0D}: return 38; {5'h10,5'h11}: return 39;
      {5'h10,5'h12}: return 40; {5'h11,5'h0D}: return 41;
      {5'h11,5'h10}: return 42; {5'h12,5'h13}: return 43;
      {5'h12,5'h14}: return 44; {5'h13,5'h0D}: return 45;
      {5'h16,5'h17}: return 46; {5'h17,5'h00}: return 47;
      {5'h17,5'h18}: return 48; {5'h18,5'h00}: return 49;
      {5'h19,5'h05}: return 50; {5'h19,5'h1A}: return 51;
      {5'h1A,5'h1B}: return 52; {5'h1B,5'h1C}: return 53;
      {5'h1C,5'h00}: return 54; {5'h1D,5'h1F}: return 55;
      {5'h1F,5'h05}: return 56;
      default: return -1;
    endcase
  endfunction

  function automatic logic [56:0] bitOf(input logic [4:0] f, input logic [4:0] t);
    int k;
    k = arcIdx(f, t);
    return (k < 0) ? 57'd0 : (57'd1 << k);
  endfunction

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; sampleValid = 1'b0; errClear = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // One cycle of stimulus; outputs are read at the following negedge
  task automatic drive(input logic v, input logic [4:0] c, input logic clr);
    @(negedge clk);
    sampleValid = v; sampleCode = c; errClear = clr;
    @(negedge clk);
    sampleValid = 1'b0; errClear = 1'b0;
  endtask

  task automatic smp(input logic [4:0] c);
    drive(1'b1, c, 1'b0);
  endtask

  task automatic testReset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1", "hit during reset", {7'd0, hitVec}, 64'd0);
    check("R1", "err during reset", {63'd0, errFlag}, 64'd0);
    check("R1", "pair during reset", {54'd0, errFrom, errTo}, 64'd0);
    check("R1", "covered during reset", {63'd0, allCovered}, 64'd0);
    rst = 1'b0;
  endtask

  task automatic testFirstSample();
    doReset();
    smp(5'h07);
    check("R2", "first sample hit", {7'd0, hitVec}, 64'd0);
    check("R2", "first sample err", {63'd0, errFlag}, 64'd0);
    smp(5'h08);
    check("R2", "move after first", {7'd0, hitVec}, {7'd0, bitOf(5'h07, 5'h08)});
  endtask

  task automatic testRepeat();
    doReset();
    smp(5'h00); smp(5'h00); smp(5'h00);
    check("R3", "repeat hit", {7'd0, hitVec}, 64'd0);
    check("R3", "repeat err", {63'd0, errFlag}, 64'd0);
    smp(5'h01);
    check("R3", "move after repeats", {7'd0, hitVec}, 64'd1);
  endtask

  task automatic testPaths();
    logic [4:0]  p1 [9] = '{5'h00,5'h01,5'h02,5'h04,5'h07,5'h08,5'h09,5'h05,5'h00};
    logic [4:0]  p2 [7] = '{5'h0C,5'h10,5'h11,5'h10,5'h12,5'h14,5'h14};
    logic [56:0] exp;
    doReset();
    exp = '0;
    smp(p1[0]);
    for (int i = 1; i < 9; i++) begin
      smp(p1[i]);
      exp |= bitOf(p1[i-1], p1[i]);
      check("R4", "training path hit", {7'd0, hitVec}, {7'd0, exp});
    end
    check("R4", "training path err", {63'd0, errFlag}, 64'd0);
    doReset();
    exp = '0;
    smp(p2[0]);
    for (int i = 1; i < 7; i++) begin
      smp(p2[i]);
      if (p2[i] != p2[i-1]) exp |= bitOf(p2[i-1], p2[i]);
    end
    check("R4", "power path hit", {7'd0, hitVec}, {7'd0, exp});
    check("R4", "power path bit 44", {63'd0, hitVec[44]}, 64'd1);
    check("R4", "power path err", {63'd0, errFlag}, 64'd0);
  endtask

  task automatic testIllegal();
    doReset();
    smp(5'h00); smp(5'h02);
    check("R5", "illegal err", {63'd0, errFlag}, 64'd1);
    check("R5", "illegal pair", {54'd0, errFrom, errTo}, {54'd0, 5'h00, 5'h02});
    check("R5", "illegal hit", {7'd0, hitVec}, 64'd0);
    smp(5'h00);
    check("R7", "second violation pair", {54'd0, errFrom, errTo}, {54'd0, 5'h00, 5'h02});
    check("R7", "second violation flag", {63'd0, errFlag}, 64'd1);
    drive(1'b0, 5'h00, 1'b1);
    check("R8", "clear alone", {63'd0, errFlag}, 64'd0);
    drive(1'b1, 5'h14, 1'b1);
    check("R8", "clear with violation flag", {63'd0, errFlag}, 64'd1);
    check("R8", "clear with violation pair", {54'd0, errFrom, errTo}, {54'd0, 5'h00, 5'h14});
  endtask

  task automatic testHoles();
    doReset();
    smp(5'h15);
    check("R6", "hole first err", {63'd0, errFlag}, 64'd1);
    check("R6", "hole first pair", {54'd0, errFrom, errTo}, {54'd0, 5'h15, 5'h15});
    doReset();
    smp(5'h10); smp(5'h1E);
    check("R6", "hole after code err", {63'd0, errFlag}, 64'd1);
    check("R6", "hole after code pair", {54'd0, errFrom, errTo}, {54'd0, 5'h10, 5'h1E});
  endtask

  task automatic testInvalid();
    doReset();
    smp(5'h00);
    drive(1'b0, 5'h1E, 1'b0);
    drive(1'b0, 5'h0C, 1'b0);
    check("R9", "invalid err", {63'd0, errFlag}, 64'd0);
    check("R9", "invalid hit", {7'd0, hitVec}, 64'd0);
    smp(5'h01);
    check("R9", "move judged from kept code", {7'd0, hitVec}, 64'd1);
    check("R9", "move err", {63'd0, errFlag}, 64'd0);
  endtask

  task automatic testCoverage();
    doReset();
    for (int f = 0; f < 32; f++) begin
      for (int t = 0; t < 32; t++) begin
        if (arcIdx(5'(f), 5'(t)) >= 0) begin
          smp(5'(f)); smp(5'(t));
        end
      end
    end
    check("R10", "all hits", {7'd0, hitVec}, {7'd0, {57{1'b1}}});
    check("R10", "covered", {63'd0, allCovered}, 64'd1);
    smp(5'h14); smp(5'h14);
    check("R10", "hits kept", {7'd0, hitVec}, {7'd0, {57{1'b1}}});
    doReset();
    check("R10", "hits after reset", {7'd0, hitVec}, 64'd0);
    check("R10", "covered after reset", {63'd0, allCovered}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    testReset();
    testFirstSample();
    testRepeat();
    testPaths();
    testIllegal();
    testHoles();
    testInvalid();
    testCoverage();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule